// File: doc/BRIEF.md
# Rotating Tiled View Address Generator

This block converts a pixel coordinate into an address in a tiled address space where the same surface can be seen through eight views: unrotated, rotated by 90, 180 or 270 degrees, each with or without mirroring. A client presents a pixel format, a view code and an (x, y) position. One clock later the block returns the tiled address of that pixel and the line stride that a scan in the chosen view must use.

The view is built from three independent operations on the coordinate. Either axis can be mirrored by inverting all of its usable bits. The two axes can also be swapped when the coordinates are linearized. Wider pixel formats give up low coordinate bits, so the usable range of each axis shrinks. The linear offset is then scaled back up by the same number of bits. The format and view codes are placed in the top five address bits. Coordinates outside the container, and the page-mode format, which has no two-dimensional view here, are reported through an error flag.

Top module: `tile_view_agen`

## Requirements
- R1: The format code is copied to address bits [28:27]: 0 is 8-bit, 1 is 16-bit, 2 is 32-bit. Code 3 (page mode) sets the error flag and returns an address of 0 and a stride of 0.
- R2: The view code is copied to address bits [31:29]. Bit 0 of the code mirrors x, bit 1 mirrors y and bit 2 swaps the axes.
- R3: The 8-bit format drops no coordinate bits. The 16-bit format drops one y bit and the 32-bit format drops one x bit and one y bit. The usable x width is 14 minus the dropped x bits, and the usable y width is 13 minus the dropped y bits.
- R4: When x or y exceeds the largest value its usable width can hold, the error flag is set and the address is 0. The stride is still reported for the format and view.
- R5: Mirroring an axis replaces the coordinate with its bitwise XOR against that axis's all-ones usable mask.
- R6: Without a swap, the linear offset is (y << usable_x_width) + x. With a swap, it is (x << usable_y_width) + y. Both use the mirrored coordinates.
- R7: The linear offset is shifted left by the total number of dropped bits and placed in address bits [26:0].
- R8: Without a swap, the stride is 1 << (14 + dropped y bits). With a swap, it is 1 << (13 + dropped x bits).
- R9: The response appears exactly one clock after the request. rsp_valid follows req_valid with that delay, and all response fields hold their values while no request is presented.
- R10: During and after reset, before any request, rsp_valid, rsp_err, rsp_addr and rsp_stride are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe |
| req_fmt | input | 2 | Pixel format code |
| req_orient | input | 3 | View code (bit0 x mirror, bit1 y mirror, bit2 swap) |
| req_x | input | 14 | Pixel column |
| req_y | input | 13 | Pixel row |
| rsp_valid | output | 1 | Response strobe, one clock after the request |
| rsp_err | output | 1 | Coordinate out of range or page-mode format |
| rsp_addr | output | 32 | Tiled view address |
| rsp_stride | output | 32 | Line stride of the chosen view |

## Verification
The range check and mirroring act on the same coordinate in the same cycle. Mirroring an out-of-range coordinate could fold it back into range and hide the error. The bench provokes this by sending, with the x-mirror and y-mirror bits set, the first value past each axis's mask for the 16-bit and 32-bit formats. It judges the response as correct only if the error flag is set and the address is 0. Axis swap and mirroring also meet in one request: in the 90-degree mirrored and 270-degree views, the bench checks that mirroring happens before linearization.

// File: rtl/tile_view_pkg.sv
package tile_view_pkg;

   typedef enum logic [1:0] {
      FMT_B8   = 2'd0,
      FMT_B16  = 2'd1,
      FMT_B32  = 2'd2,
      FMT_PAGE = 2'd3
   } pix_fmt_e;

   typedef struct packed {
      logic swap;
      logic mir_y;
      logic mir_x;
   } view_ctl_t;

   // low x bits given up by a format
   function automatic logic drop_x(input pix_fmt_e f);
      return (f == FMT_B32);
   endfunction

   // low y bits given up by a format
   function automatic logic drop_y(input pix_fmt_e f);
      return (f == FMT_B16) || (f == FMT_B32);
   endfunction

endpackage

// File: rtl/tile_view_geom.sv
module tile_view_geom
   import tile_view_pkg::*;
#(
   parameter int CW_BITS = 14,
   parameter int CH_BITS = 13
) (
   input  logic [1:0]         fmt,
   output logic               xs,
   output logic               ys,
   output logic [CW_BITS-1:0] x_mask,
   output logic [CH_BITS-1:0] y_mask,
   output logic               fmt_bad
);
   pix_fmt_e f;

   always_comb begin
      f       = pix_fmt_e'(fmt);
      fmt_bad = (f == FMT_PAGE);
      xs      = fmt_bad ? 1'b0 : drop_x(f);
      ys      = fmt_bad ? 1'b0 : drop_y(f);
      x_mask  = {CW_BITS{1'b1}} >> xs;
      y_mask  = {CH_BITS{1'b1}} >> ys;
   end
endmodule

// File: rtl/tile_view_xform.sv
module tile_view_xform
   import tile_view_pkg::*;
#(
   parameter int CW_BITS = 14,
   parameter int CH_BITS = 13
) (
   input  logic [CW_BITS-1:0] x_in,
   input  logic [CH_BITS-1:0] y_in,
   input  logic [CW_BITS-1:0] x_mask,
   input  logic [CH_BITS-1:0] y_mask,
   input  view_ctl_t          ctl,
   output logic [CW_BITS-1:0] x_out,
   output logic [CH_BITS-1:0] y_out,
   output logic               range_bad
);
   logic x_over, y_over;

   always_comb begin
      x_over    = |(x_in & ~x_mask);
      y_over    = |(y_in & ~y_mask);
      range_bad = x_over | y_over;
      x_out     = ctl.mir_x ? (x_in ^ x_mask) : x_in;
      y_out     = ctl.mir_y ? (y_in ^ y_mask) : y_in;
   end
endmodule

// File: rtl/tile_view_pack.sv
module tile_view_pack
   import tile_view_pkg::*;
#(
   parameter int CW_BITS = 14,
   parameter int CH_BITS = 13,
   parameter int ADDR_W  = 32
) (
   input  logic [CW_BITS-1:0] xm,
   input  logic [CH_BITS-1:0] ym,
   input  logic               xs,
   input  logic               ys,
   input  logic [1:0]         fmt,
   input  logic [2:0]         orient,
   input  logic               fmt_bad,
   input  logic               any_bad,
   output logic [ADDR_W-1:0]  addr,
   output logic [ADDR_W-1:0]  stride
);
   localparam int OFF_W = CW_BITS + CH_BITS;
   localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

   generate
      if (ADDR_W != OFF_W + 5) begin : g_bad_width
         $error("tile_view_pack: address must hold offset plus five code bits");
      end
   endgenerate

   view_ctl_t         ctl;
   logic [OFF_W-1:0]  xw, yw, lin, lin_sh;
   logic [1:0]        align;

   always_comb begin
      ctl   = view_ctl_t'(orient);
      xw    = OFF_W'(xm);
      yw    = OFF_W'(ym);
      align = {1'b0, xs} + {1'b0, ys};
      if (ctl.swap)
         lin = (ys ? (xw << (CH_BITS - 1)) : (xw << CH_BITS)) + yw;
      else
         lin = (xs ? (yw << (CW_BITS - 1)) : (yw << CW_BITS)) + xw;
      lin_sh = lin << align;

      addr = any_bad ? '0 : {orient, fmt, lin_sh};

      if (fmt_bad)
         stride = '0;
      else if (ctl.swap)
         stride = xs ? (ONE << (CH_BITS + 1)) : (ONE << CH_BITS);
      else
         stride = ys ? (ONE << (CW_BITS + 1)) : (ONE << CW_BITS);
   end
endmodule

// File: rtl/tile_view_agen.sv
module tile_view_agen
   import tile_view_pkg::*;
#(
   parameter int CW_BITS = 14,
   parameter int CH_BITS = 13,
   parameter int ADDR_W  = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic [1:0]         req_fmt,
   input  logic [2:0]         req_orient,
   input  logic [CW_BITS-1:0] req_x,
   input  logic [CH_BITS-1:0] req_y,
   output logic               rsp_valid,
   output logic               rsp_err,
   output logic [ADDR_W-1:0]  rsp_addr,
   output logic [ADDR_W-1:0]  rsp_stride
);
   generate
      if (CW_BITS < 2 || CH_BITS < 2) begin : g_bad_dims
         $error("tile_view_agen: container axes need at least two bits");
      end
   endgenerate

   logic               xs, ys, fmt_bad, range_bad, any_bad;
   logic [CW_BITS-1:0] x_mask, xm;
   logic [CH_BITS-1:0] y_mask, ym;
   logic [ADDR_W-1:0]  addr_c, stride_c;

   tile_view_geom #(.CW_BITS(CW_BITS), .CH_BITS(CH_BITS)) u_geom (
      .fmt(req_fmt), .xs(xs), .ys(ys),
      .x_mask(x_mask), .y_mask(y_mask), .fmt_bad(fmt_bad)
   );

   tile_view_xform #(.CW_BITS(CW_BITS), .CH_BITS(CH_BITS)) u_xform (
      .x_in(req_x), .y_in(req_y), .x_mask(x_mask), .y_mask(y_mask),
      .ctl(view_ctl_t'(req_orient)), .x_out(xm), .y_out(ym),
      .range_bad(range_bad)
   );

   assign any_bad = fmt_bad | range_bad;

   tile_view_pack #(.CW_BITS(CW_BITS), .CH_BITS(CH_BITS), .ADDR_W(ADDR_W)) u_pack (
      .xm(xm), .ym(ym), .xs(xs), .ys(ys), .fmt(req_fmt), .orient(req_orient),
      .fmt_bad(fmt_bad), .any_bad(any_bad), .addr(addr_c), .stride(stride_c)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid  <= 1'b0;
         rsp_err    <= 1'b0;
         rsp_addr   <= '0;
         rsp_stride <= '0;
      end else begin
         rsp_valid <= req_valid;
         if (req_valid) begin
            rsp_err    <= any_bad;
            rsp_addr   <= addr_c;
            rsp_stride <= stride_c;
         end
      end
   end

   // R9: response strobe trails the request by one clock
   p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);
   p_no_spurious_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (!rsp_valid && $stable(rsp_addr) && $stable(rsp_stride)));
   // R1: page mode is always flagged
   p_page_err_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_fmt == 2'd3) |=> (rsp_err && rsp_stride == '0));
   // R4: an error never leaks an address
   p_err_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_err) |-> (rsp_addr == '0));
   // R2: code fields carried into the address
   p_fields_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_fmt != 2'd3) |=>
         (rsp_err || (rsp_addr[ADDR_W-1 -: 3] == $past(req_orient)
                      && rsp_addr[ADDR_W-4 -: 2] == $past(req_fmt))));
   // R8: stride is a single power of two or zero
   p_stride_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $onehot0(rsp_stride));
   // R7: 32-bit addresses are aligned to four
   p_align_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_err && rsp_addr[ADDR_W-4 -: 2] == 2'd2) |-> (rsp_addr[1:0] == 2'b00));
endmodule

// File: tb/tile_view_agen_bench.sv
module tile_view_agen_bench;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [1:0]  req_fmt = '0;
   logic [2:0]  req_orient = '0;
   logic [13:0] req_x = '0;
   logic [12:0] req_y = '0;
   logic        rsp_valid, rsp_err;
   logic [31:0] rsp_addr, rsp_stride;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   tile_view_agen u_tile_view_agen (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_fmt(req_fmt),
      .req_orient(req_orient), .req_x(req_x), .req_y(req_y),
      .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_addr(rsp_addr),
      .rsp_stride(rsp_stride)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic void model(input logic [1:0] f, input logic [2:0] o,
                                 input logic [13:0] x, input logic [12:0] y,
                                 output logic [31:0] a, output logic [31:0] s,
                                 output logic e);
      int xs, ys, xb, yb;
      logic [31:0] xm, ym, off;
      a = 0; s = 0; e = 1'b1;
      if (f == 2'd3) return;
      xs = (f == 2'd2) ? 1 : 0;
      ys = (f != 2'd0) ? 1 : 0;
      xb = 14 - xs;
      yb = 13 - ys;
      s = o[2] ? (32'd1 << (13 + xs)) : (32'd1 << (14 + ys));
      if ({18'd0, x} >= (32'd1 << xb) || {19'd0, y} >= (32'd1 << yb)) return;
      xm = {18'd0, x};
      ym = {19'd0, y};
      if (o[0]) xm = xm ^ ((32'd1 << xb) - 1);
      if (o[1]) ym = ym ^ ((32'd1 << yb) - 1);
      off = o[2] ? ((xm << yb) + ym) : ((ym << xb) + xm);
      off = off << (xs + ys);
      a = {o, f, 27'd0} | off;
      e = 1'b0;
   endfunction

   task automatic run_req(input logic [1:0] f, input logic [2:0] o,
                          input logic [13:0] x, input logic [12:0] y,
                          input string req);
      logic [31:0] ea, es;
      logic ee;
      model(f, o, x, y, ea, es, ee);
      @(negedge clk);
      req_valid = 1'b1; req_fmt = f; req_orient = o; req_x = x; req_y = y;
      @(negedge clk);
      req_valid = 1'b0;
      chk("R9", "valid", {31'd0, rsp_valid}, 32'd1);
      chk(req, "err", {31'd0, rsp_err}, {31'd0, ee});
      chk(req, "addr", rsp_addr, ea);
      chk(req, "stride", rsp_stride, es);
   endtask

   task automatic t_reset;
      chk("R10", "valid", {31'd0, rsp_valid}, 32'd0);
      chk("R10", "err", {31'd0, rsp_err}, 32'd0);
      chk("R10", "addr", rsp_addr, 32'd0);
      chk("R10", "stride", rsp_stride, 32'd0);
   endtask

   task automatic t_literal;
      // 32-bit, unrotated, (1,1): offset (1<<13)+1 scaled by 4
      run_req(2'd2, 3'd0, 14'd1, 13'd1, "R7");
      chk("R1", "literal", rsp_addr, 32'h1000_8004);
      // 8-bit, unrotated, (5,3)
      run_req(2'd0, 3'd0, 14'd5, 13'd3, "R6");
      chk("R6", "literal", rsp_addr, 32'h0000_C005);
   endtask

   task automatic t_formats;
      for (int f = 0; f < 3; f++) begin
         run_req(2'(f), 3'd0, 14'd100, 13'd77, "R3");
         run_req(2'(f), 3'd0, 14'd4095, 13'd4095, "R1");
      end
   endtask

   task automatic t_views;
      for (int f = 0; f < 3; f++)
         for (int o = 0; o < 8; o++) begin
            run_req(2'(f), 3'(o), 14'd37, 13'd1021, "R2");
            run_req(2'(f), 3'(o), 14'd0, 13'd0, "R5");
         end
      run_req(2'd0, 3'd4, 14'd16383, 13'd8191, "R6");
      run_req(2'd1, 3'd5, 14'd9000, 13'd4095, "R8");
   endtask

   task automatic t_range;
      run_req(2'd2, 3'd0, 14'd8191, 13'd4095, "R4");
      run_req(2'd2, 3'd0, 14'd8192, 13'd0, "R4");
      run_req(2'd1, 3'd0, 14'd0, 13'd4096, "R4");
      // mirroring must not rescue an out-of-range coordinate
      run_req(2'd2, 3'd3, 14'd8192, 13'd5, "R4");
      run_req(2'd1, 3'd7, 14'd10, 13'd4096, "R4");
      chk("R4", "mirror-addr", rsp_addr, 32'd0);
   endtask

   task automatic t_page;
      run_req(2'd3, 3'd0, 14'd1, 13'd1, "R1");
      run_req(2'd3, 3'd6, 14'd16383, 13'd8191, "R1");
   endtask

   task automatic t_hold;
      logic [31:0] a0, s0;
      run_req(2'd1, 3'd6, 14'd1234, 13'd567, "R9");
      a0 = rsp_addr; s0 = rsp_stride;
      req_fmt = 2'd3; req_x = 14'd99; req_orient = 3'd1;
      repeat (3) @(negedge clk);
      chk("R9", "idle-valid", {31'd0, rsp_valid}, 32'd0);
      chk("R9", "idle-addr", rsp_addr, a0);
      chk("R9", "idle-stride", rsp_stride, s0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_literal();
      t_formats();
      t_views();
      t_range();
      t_page();
      t_hold();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule